// File: doc/BRIEF.md
# Masked Content-Addressable Memory with Highest-Index Priority

This block is a synchronous content-addressable memory holding 512 words of 64 bits, each with its own valid flag. A single command port selects, each clock, one of a few operations: an addressed write (which also marks the row valid), an addressed invalidate, an addressed read, or a search. Storage is built from flip-flops. A search presents a key and a global bit mask. Every valid row compares its word with the key on the bit positions the mask enables.

Each row drives its own match line. A row's line is high only when all of the enabled bits agree. The match lines are captured into a register one clock after the search command. A priority encoder then turns them into a hit flag and the highest matching row index. The captured match vector is also brought out on a port, so the encoder can be checked separately from the comparison logic.

Search and read results each come with a one-cycle done strobe. They hold their values until the next operation of the same kind.

Top module: `mask_cam`

## Requirements
- R1: While reset (rst_n low, sampled at a rising edge) is applied, all valid flags are cleared, along with both done strobes and the match vector. After reset, no search hits and every read reports the entry as not valid.
- R2: Command code 2 (write) stores wdata at row addr and sets that row's valid flag. Command code 1 (read) returns the stored word on rd_data and the row's valid flag on rd_entry_valid. Both appear with rd_done high on the clock after the command.
- R3: Command code 3 (search) raises srch_done on the clock after the command. If any row matches, hit is 1 and hit_addr gives a matching row index.
- R4: A mask bit of 1 includes that bit position in the comparison. A mask bit of 0 excludes it, so that position always counts as agreeing.
- R5: Command code 4 (invalidate) clears the valid flag of row addr. A row whose valid flag is clear never matches, and a read of it reports rd_entry_valid = 0.
- R6: When several rows match, hit_addr is the highest matching row index.
- R7: A row matches only when every enabled bit is equal. A single differing enabled bit removes the match. When no row matches, hit is 0.
- R8: A search with an all-zero mask matches every valid row, so hit_addr is the highest valid row index.
- R9: After a search, bit i of match_vec is 1 exactly when row i matched. This vector appears in the same cycle as hit and hit_addr.
- R10: Codes 0, 5, 6 and 7 do nothing. srch_done and rd_done go high only on the clock after a search or a read command. The search outputs hold their values until the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Operation code: 0 none, 1 read, 2 write, 3 search, 4 invalidate |
| addr | input | 9 | Row index for read, write and invalidate |
| wdata | input | 64 | Word to store on write |
| key | input | 64 | Comparand for search |
| mask | input | 64 | Per-bit compare enable for search (1 = compared) |
| rd_done | output | 1 | One-cycle strobe: read result valid |
| rd_data | output | 64 | Word read from the addressed row |
| rd_entry_valid | output | 1 | Valid flag of the row that was read |
| srch_done | output | 1 | One-cycle strobe: search result valid |
| hit | output | 1 | At least one row matched the last search |
| hit_addr | output | 9 | Highest matching row index (meaningless when hit is 0) |
| match_vec | output | 512 | Captured per-row match lines of the last search |

## Verification
Several kinds of search are tried, each separating one rule from the others:
- Exact full-mask keys against unique words check basic equality.
- The same word stored in rows 7, 300 and 511 tells highest-index priority apart from first-found or lowest-index selection.
- A key that differs in one bit is searched twice: once with that bit masked off and once fully compared. This distinguishes masking from plain equality.
- All-zero masks before and after an invalidate show that only valid rows take part, and that the top valid index wins.

A pseudo-random series of writes and partially masked searches is run against a model of the expected behaviour. It compares the full match vector as well as the encoded result, so faults in the match lines can be told apart from faults in the encoder.

// File: rtl/mask_cam_pkg.sv
// Package: shared operation codes for the masked CAM.
// Assumes a 3-bit command port; unlisted codes are treated as no-ops.
package mask_cam_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_SEARCH = 3'd3,
        OP_INVAL  = 3'd4
    } cam_op_e;
endpackage

// File: rtl/cam_op_decode.sv
// Module: cam_op_decode
// Turns the raw command code into one-hot operation enables.
// Assumes one operation per cycle; reserved codes give no enable.
module cam_op_decode
    import mask_cam_pkg::*;
(
    input  logic [2:0] cmd,
    output logic       do_read,
    output logic       do_write,
    output logic       do_search,
    output logic       do_inval
);
    // Decode the command code into single enables.
    always_comb begin
        do_read   = 1'b0;
        do_write  = 1'b0;
        do_search = 1'b0;
        do_inval  = 1'b0;
        case (cmd)
            OP_READ:   do_read   = 1'b1;
            OP_WRITE:  do_write  = 1'b1;
            OP_SEARCH: do_search = 1'b1;
            OP_INVAL:  do_inval  = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/cam_row_array.sv
// Module: cam_row_array
// Flip-flop storage of ENTRIES words plus valid flags, with one
// combinational match line per row for a masked compare against key.
// Assumes addr is below ENTRIES; write takes precedence over invalidate.
module cam_row_array #(
    parameter int ENTRIES = 512,
    parameter int WIDTH   = 64,
    parameter int ADDR_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               inval_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WIDTH-1:0]   wdata,
    input  logic [WIDTH-1:0]   key,
    input  logic [WIDTH-1:0]   mask,
    output logic [WIDTH-1:0]   rd_word,
    output logic               rd_flag,
    output logic [ENTRIES-1:0] match_lines,
    output logic [ENTRIES-1:0] valid_flags
);
    logic [WIDTH-1:0]   word_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // Valid flags: cleared by reset, set by write, cleared by invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[addr] <= 1'b1;
        end else if (inval_en) begin
            valid_q[addr] <= 1'b0;
        end
    end

    // Word storage: written on write only, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[addr] <= wdata;
        end
    end

    // Per-row match line: any enabled differing bit pulls the line low.
    for (genvar r = 0; r < ENTRIES; r++) begin : g_row
        logic [WIDTH-1:0] diff_bits;
        assign diff_bits      = (word_q[r] ^ key) & mask;
        assign match_lines[r] = valid_q[r] & ~(|diff_bits);
    end

    assign rd_word     = word_q[addr];
    assign rd_flag     = valid_q[addr];
    assign valid_flags = valid_q;
endmodule

// File: rtl/cam_prio_enc.sv
// Module: cam_prio_enc
// Reduces N request lines to an any-set flag and the index of the
// highest set line. Assumes IDX_W is wide enough to hold N-1.
module cam_prio_enc #(
    parameter int N     = 512,
    parameter int IDX_W = 9
) (
    input  logic [N-1:0]     lines,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan upward so the last (highest) set line overrides lower ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lines[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mask_cam.sv
// Module: mask_cam (top)
// Masked content-addressable memory: addressed read/write/invalidate and
// a search that registers the per-row match lines one clock after the
// command, then priority-encodes them to the highest matching index.
// Assumes one command per cycle and synchronous active-low reset.
module mask_cam #(
    parameter int ENTRIES = 512,
    parameter int WIDTH   = 64,
    parameter int ADDR_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cmd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WIDTH-1:0]   wdata,
    input  logic [WIDTH-1:0]   key,
    input  logic [WIDTH-1:0]   mask,
    output logic               rd_done,
    output logic [WIDTH-1:0]   rd_data,
    output logic               rd_entry_valid,
    output logic               srch_done,
    output logic               hit,
    output logic [ADDR_W-1:0]  hit_addr,
    output logic [ENTRIES-1:0] match_vec
);
    logic               do_read, do_write, do_search, do_inval;
    logic [WIDTH-1:0]   rd_word;
    logic               rd_flag;
    logic [ENTRIES-1:0] match_lines;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] match_q;
    logic               srch_done_q, rd_done_q, rd_flag_q;
    logic [WIDTH-1:0]   rd_data_q;

    cam_op_decode u_dec (
        .cmd       (cmd),
        .do_read   (do_read),
        .do_write  (do_write),
        .do_search (do_search),
        .do_inval  (do_inval)
    );

    cam_row_array #(
        .ENTRIES (ENTRIES),
        .WIDTH   (WIDTH),
        .ADDR_W  (ADDR_W)
    ) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (do_write),
        .inval_en    (do_inval),
        .addr        (addr),
        .wdata       (wdata),
        .key         (key),
        .mask        (mask),
        .rd_word     (rd_word),
        .rd_flag     (rd_flag),
        .match_lines (match_lines),
        .valid_flags (valid_vec)
    );

    // Search stage: capture match lines on a search, strobe done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q     <= '0;
            srch_done_q <= 1'b0;
        end else begin
            srch_done_q <= do_search;
            if (do_search) begin
                match_q <= match_lines;
            end
        end
    end

    // Read stage: capture addressed word and flag on a read, strobe done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            rd_flag_q <= 1'b0;
            rd_done_q <= 1'b0;
        end else begin
            rd_done_q <= do_read;
            if (do_read) begin
                rd_data_q <= rd_word;
                rd_flag_q <= rd_flag;
            end
        end
    end

    cam_prio_enc #(
        .N     (ENTRIES),
        .IDX_W (ADDR_W)
    ) u_enc (
        .lines (match_q),
        .any   (hit),
        .idx   (hit_addr)
    );

    assign match_vec      = match_q;
    assign srch_done      = srch_done_q;
    assign rd_done        = rd_done_q;
    assign rd_data        = rd_data_q;
    assign rd_entry_valid = rd_flag_q;
endmodule

// File: rtl/mask_cam_chk.sv
// Module: mask_cam_chk
// Property checker bound to mask_cam. Observes ports plus the row valid
// flags; assumes the command encoding of mask_cam_pkg.
module mask_cam_chk #(
    parameter int ENTRIES = 512,
    parameter int ADDR_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         cmd,
    input logic               rd_done,
    input logic               srch_done,
    input logic               hit,
    input logic [ADDR_W-1:0]  hit_addr,
    input logic [ENTRIES-1:0] match_vec,
    input logic [ENTRIES-1:0] valid_vec
);
    // R1: reset empties the valid flags and silences the search strobe.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0 && !srch_done));

    // R2: a read command is answered on the next clock.
    assert_read_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1) |=> rd_done);

    // R10: search strobe follows exactly the search commands.
    assert_search_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd3) |=> srch_done);
    assert_no_stray_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 3'd3) |=> !srch_done);

    // R9: the reported index points at a raised match line.
    assert_addr_on_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_addr]);

    // R6: no match line above the reported index.
    assert_highest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec >> hit_addr) == ENTRIES'(1)));

    // R7: a miss means no line is raised.
    assert_miss_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (match_vec == '0));

    // R5: only rows valid at search time may match.
    assert_valid_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        srch_done |-> ((match_vec & ~$past(valid_vec)) == '0));
endmodule

bind mask_cam mask_cam_chk #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .rd_done   (rd_done),
    .srch_done (srch_done),
    .hit       (hit),
    .hit_addr  (hit_addr),
    .match_vec (match_vec),
    .valid_vec (valid_vec)
);

// File: tb/mask_cam_tb.sv
// Scoreboard bench for mask_cam: the driver updates a behavioural model
// and queues expected results; the monitor pops and compares them.
module mask_cam_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 512;
    localparam int W  = 64;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd = 3'd0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0, key = '0, mask = '0;
    logic          rd_done, rd_entry_valid, srch_done, hit;
    logic [W-1:0]  rd_data;
    logic [AW-1:0] hit_addr;
    logic [N-1:0]  match_vec;

    mask_cam #(.ENTRIES(N), .WIDTH(W), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
        .key(key), .mask(mask), .rd_done(rd_done), .rd_data(rd_data),
        .rd_entry_valid(rd_entry_valid), .srch_done(srch_done), .hit(hit),
        .hit_addr(hit_addr), .match_vec(match_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural model.
    logic [W-1:0] m_word [N];
    bit           m_valid [N];

    // Expectation queues (parallel).
    bit           q_srch [$];
    int           q_due [$];
    bit           q_hit [$];
    int           q_addr [$];
    logic [N-1:0] q_vec [$];
    logic [W-1:0] q_data [$];
    bit           q_flag [$];
    string        q_req [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_search(input logic [W-1:0] k, input logic [W-1:0] m,
                                         output bit h, output int a, output logic [N-1:0] v);
        h = 1'b0; a = 0; v = '0;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && (((m_word[i] ^ k) & m) == '0)) begin
                v[i] = 1'b1; h = 1'b1; a = i;
            end
        end
    endfunction

    // Driver: issue one command, update model, queue expectations.
    task automatic op(input logic [2:0] c, input int a, input logic [W-1:0] d,
                      input logic [W-1:0] k, input logic [W-1:0] m, input string req);
        bit h; int ha; logic [N-1:0] v;
        @(negedge clk);
        cmd = c; addr = AW'(a); wdata = d; key = k; mask = m;
        case (c)
            3'd1: begin
                q_srch.push_back(1'b0); q_due.push_back(cyc + 1);
                q_hit.push_back(1'b0); q_addr.push_back(0); q_vec.push_back('0);
                q_data.push_back(m_word[a]); q_flag.push_back(m_valid[a]);
                q_req.push_back(req);
            end
            3'd2: begin m_word[a] = d; m_valid[a] = 1'b1; end
            3'd3: begin
                model_search(k, m, h, ha, v);
                q_srch.push_back(1'b1); q_due.push_back(cyc + 1);
                q_hit.push_back(h); q_addr.push_back(ha); q_vec.push_back(v);
                q_data.push_back('0); q_flag.push_back(1'b0);
                q_req.push_back(req);
            end
            3'd4: m_valid[a] = 1'b0;
            default: ;
        endcase
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd = 3'd0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare strobed results with the queue front.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (srch_done || rd_done) begin
                if (q_due.size() == 0) begin
                    check(1'b0, "R10", "unexpected strobe", N'(srch_done), '0);
                end else begin
                    bit s; int due; bit eh; int ea; logic [N-1:0] ev;
                    logic [W-1:0] ed; bit ef; string r;
                    s = q_srch.pop_front(); due = q_due.pop_front();
                    eh = q_hit.pop_front(); ea = q_addr.pop_front();
                    ev = q_vec.pop_front(); ed = q_data.pop_front();
                    ef = q_flag.pop_front(); r = q_req.pop_front();
                    check(due == cyc, "R10", "strobe cycle", N'(cyc), N'(due));
                    if (s) begin
                        check(srch_done && !rd_done, r, "search strobe", N'(srch_done), 1);
                        check(hit == eh, r, "hit", N'(hit), N'(eh));
                        if (eh) check(int'(hit_addr) == ea, r, "hit_addr",
                                      N'(hit_addr), N'(ea));
                        check(match_vec == ev, r, "match_vec (R9)", match_vec, ev);
                    end else begin
                        check(rd_done && !srch_done, r, "read strobe", N'(rd_done), 1);
                        check(rd_entry_valid == ef, r, "rd_entry_valid",
                              N'(rd_entry_valid), N'(ef));
                        if (ef) check(rd_data == ed, r, "rd_data", N'(rd_data), N'(ed));
                    end
                end
            end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
                check(1'b0, q_req[0], "missing strobe", '0, 1);
                void'(q_due.pop_front()); void'(q_srch.pop_front());
                void'(q_hit.pop_front()); void'(q_addr.pop_front());
                void'(q_vec.pop_front()); void'(q_data.pop_front());
                void'(q_flag.pop_front()); void'(q_req.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] WA = 64'hA5A5_0000_1234_5678;
    localparam logic [W-1:0] WB = 64'h0F0F_F0F0_DEAD_BEEF;
    localparam logic [W-1:0] WC = 64'h1111_2222_3333_4444;
    localparam logic [W-1:0] WS = 64'hCAFE_0000_0000_5A5A;
    localparam logic [W-1:0] WZ = 64'h7777_0000_0000_0001;

    initial begin
        logic [31:0] lfsr;
        logic [W-1:0] saved [8];
        for (int i = 0; i < N; i++) begin m_word[i] = '0; m_valid[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs after reset.
        check(!srch_done && !rd_done, "R1", "strobes after reset", N'(srch_done), 0);
        check(!hit, "R1", "hit after reset", N'(hit), 0);
        check(match_vec == '0, "R1", "match_vec after reset", match_vec, '0);
        op(3'd3, 0, '0, '0, '0, "R1");           // all-zero mask, nothing valid
        op(3'd1, 5, '0, '0, '0, "R1");           // read of empty row

        // R2: write and read back, including both boundary rows.
        op(3'd2, 3, WA, '0, '0, "R2");
        op(3'd2, 100, WB, '0, '0, "R2");
        op(3'd2, 511, WC, '0, '0, "R2");
        op(3'd1, 3, '0, '0, '0, "R2");
        op(3'd1, 100, '0, '0, '0, "R2");
        op(3'd1, 511, '0, '0, '0, "R2");

        // R3: exact full-mask search.
        op(3'd3, 0, '0, WB, ONES, "R3");

        // R6: same word in several rows; highest wins.
        op(3'd2, 7, WS, '0, '0, "R6");
        op(3'd2, 300, WS, '0, '0, "R6");
        op(3'd3, 0, '0, WS, ONES, "R6");
        op(3'd2, 511, WS, '0, '0, "R6");
        op(3'd3, 0, '0, WS, ONES, "R6");

        // R4 / R7: one differing bit, masked then compared.
        op(3'd3, 0, '0, WA ^ (64'd1 << 40), ~(64'd1 << 40), "R4");
        op(3'd3, 0, '0, WA ^ (64'd1 << 40), ONES, "R7");

        // R8: all-zero mask returns highest valid row (511).
        op(3'd3, 0, '0, 64'h1234, '0, "R8");

        // R5: invalidate row 511, it drops out.
        op(3'd4, 511, '0, '0, '0, "R5");
        op(3'd3, 0, '0, WS, ONES, "R5");
        op(3'd3, 0, '0, '0, '0, "R8");
        op(3'd1, 511, '0, '0, '0, "R5");

        // R10: no-op and reserved codes change nothing and raise no strobe.
        op(3'd0, 3, 64'hFFFF, '0, '0, "R10");
        op(3'd6, 3, 64'hFFFF, '0, '0, "R10");
        op(3'd7, 3, 64'hFFFF, '0, '0, "R10");
        op(3'd1, 3, '0, '0, '0, "R10");
        op(3'd3, 0, '0, WA, ONES, "R10");

        // Boundary: only row 0 matches.
        op(3'd2, 0, WZ, '0, '0, "R3");
        op(3'd3, 0, '0, WZ, ONES, "R3");

        // R9: pseudo-random writes and partially masked searches.
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            d = {lfsr, ~lfsr} & 64'hFF00_00FF_F00F_0FF0;
            if (i < 8) saved[i] = d;
            op(3'd2, int'(lfsr[8:0]), d, '0, '0, "R9");
        end
        for (int i = 0; i < 8; i++) begin
            op(3'd3, 0, '0, saved[i], ONES, "R9");
            op(3'd3, 0, '0, saved[i], 64'hFF00_0000_0000_0000, "R9");
        end
        idle(4);
        check(q_due.size() == 0, "R10", "results outstanding", N'(q_due.size()), 0);
        finish_run();
    end
endmodule